// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Controller

This block is the interrupt front end of a two-channel serial peripheral that sits on a processor bus using a priority daisy chain. Each channel raises three kinds of request: receive, transmit and external/status. The block ranks the six requests with a fixed priority and drives an active-low request line to the processor. It takes part in the chain through an enable input from the upstream device and an enable output to the downstream device.

When the processor acknowledges, the winning source places an 8-bit vector on the bus and sets its own under-service latch. The vector is either the programmed base value or the base with three bits replaced by a code that names the source. The block also watches instruction fetches for the two-byte return-from-interrupt sequence. The first byte temporarily opens the chain past requests that are still waiting. When the second byte matches, the source being serviced is released.

Bus strobes are sampled on the rising edge of a block clock. A fetch is any cycle with fetch strobe low, read strobe low and I/O request strobe high. The opcode byte is the last value on the data input during the fetch, and it takes effect at the first edge after the fetch ends.

Top module: `irq_chain_ctrl`

## Requirements
- R1: Sources are ranked from highest to lowest as index 0 A receive, 1 A transmit, 2 A external/status, 3 B receive, 4 B transmit, 5 B external/status (bit k of `req_i`). Only the highest-ranked source that is pending, not under service and not blocked by a higher source may win an acknowledge.
- R2: `ieo_o` is low while the upstream enable is low. It is also low while any source is under service or pending without being acknowledged, except during the relaxed window of R8. Otherwise it equals `iei_i`.
- R3: `int_no` is low exactly when some pending source is reached by the chain and is not under service. It is therefore high whenever `iei_i` is low.
- R4: An acknowledge is fetch strobe and I/O request strobe both low. From the first edge of an acknowledge, `vec_oe_o` is high with a stable `vec_o` for the rest of that acknowledge, provided a winner existed. At the same edge the winner's under-service latch sets, so the winner and all lower sources are blocked. With no winner, `vec_oe_o` stays low.
- R5: With `sav_en_i` high, vector bits 3:1 carry a source code: B transmit 000, B external 001, B receive 010, B receive with special condition 011, A transmit 100, A external 101, A receive 110, A receive with special condition 111. The other vector bits come from `vec_base_i`. `rx_spec_i` bit 0 marks channel A and bit 1 marks channel B.
- R6: With `sav_en_i` low, the vector equals `vec_base_i`.
- R7: While the fetch strobe is low, changes on `req_i` and `rx_spec_i` have no effect. They are taken at the first edge after the strobe returns high.
- R8: After a fetched byte of ED (hex), pending sources that have not been acknowledged stop blocking `ieo_o` until the next fetched byte takes effect.
- R9: A byte of 4D (hex) fetched directly after ED clears the under-service latch of the in-service source reached by the chain. Any other byte after ED clears nothing.
- R10: A higher-ranked source may request, win and be serviced while a lower one is under service. Each source has its own latch, and returns release them from the highest downward.
- R11: Reset clears all pending, under-service and decode state, leaving `int_no` high and `ieo_o` equal to `iei_i`.
- R12: A return sequence decoded while `iei_i` is low clears no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Enabled requests, bit index per R1 |
| rx_spec_i | input | 2 | Receive request is a special condition, per channel (bit 0 = A) |
| vec_base_i | input | 8 | Programmed interrupt vector |
| sav_en_i | input | 1 | Replace vector bits 3:1 with the source code |
| m1_ni | input | 1 | Fetch / acknowledge strobe, active low |
| iorq_ni | input | 1 | I/O request strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| data_i | input | 8 | Data bus as seen during fetches |
| iei_i | input | 1 | Chain enable from upstream |
| ieo_o | output | 1 | Chain enable to downstream |
| int_no | output | 1 | Interrupt request, active low |
| vec_o | output | 8 | Vector driven during acknowledge |
| vec_oe_o | output | 1 | Vector output enable |

## Verification
The assertions check the following on every cycle:
- the chain output never rises without the chain input, and the request line never drops without it;
- the vector is enabled only inside an acknowledge and holds steady while enabled;
- at most one under-service latch sets at a time, and only at an acknowledge edge.

Only the bench scenarios can show the other behaviours:
- the ranking and the vector codes;
- the release sequence and the ED relaxation;
- the freeze under the fetch strobe and the refusal to release with the chain input low;
- the nested service ordering.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   // Request kinds inside one channel, in priority order
   localparam int unsigned SRC_PER_CH = 3;
   localparam int unsigned KIND_RX    = 0;
   localparam int unsigned KIND_TX    = 1;
   localparam int unsigned KIND_EXT   = 2;

   // Two-bit kind field of the vector source code
   function automatic logic [1:0] kind_code(input int unsigned kind, input logic spec);
      logic [1:0] c;
      case (kind)
         KIND_TX:  c = 2'b00;
         KIND_EXT: c = 2'b01;
         default:  c = spec ? 2'b11 : 2'b10;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/irq_status_freeze.sv
module irq_status_freeze #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_o <= '0;
      end else if (!hold_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
   parameter int unsigned NSRC = 6
) (
   input  logic            iei_i,
   input  logic [NSRC-1:0] pend_i,
   input  logic [NSRC-1:0] ius_i,
   input  logic            relax_i,
   output logic            ieo_o,
   output logic [NSRC-1:0] grant_o,
   output logic [NSRC-1:0] svc_o
);

   // ena: chain seen by the outside (relaxable)
   // win: strict chain used for arbitration
   logic [NSRC:0] ena;
   logic [NSRC:0] win;

   assign ena[0] = iei_i;
   assign win[0] = iei_i;

   for (genvar k = 0; k < NSRC; k++) begin : g_link
      logic blk_pend;
      assign blk_pend   = pend_i[k] & ~relax_i;
      assign ena[k+1]   = ena[k] & ~ius_i[k] & ~blk_pend;
      assign win[k+1]   = win[k] & ~ius_i[k] & ~pend_i[k];
      assign grant_o[k] = win[k] & pend_i[k] & ~ius_i[k];
      assign svc_o[k]   = ena[k] & ius_i[k];
   end

   assign ieo_o = ena[NSRC];

endmodule

// File: rtl/irq_opcode_mon.sv
module irq_opcode_mon #(
   parameter int unsigned      OP_W   = 8,
   parameter logic [OP_W-1:0]  PFX_OP = 8'hED,
   parameter logic [OP_W-1:0]  RET_OP = 8'h4D
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            fetch_i,
   input  logic [OP_W-1:0] op_i,
   output logic            relax_o,
   output logic            ret_o
);

   logic            fetch_q;
   logic [OP_W-1:0] op_q;
   logic            pfx_q;
   logic            done;

   assign done = fetch_q & ~fetch_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fetch_q <= 1'b0;
         op_q    <= '0;
         pfx_q   <= 1'b0;
      end else begin
         fetch_q <= fetch_i;
         if (fetch_i) begin
            op_q <= op_i;
         end
         if (done) begin
            pfx_q <= (op_q == PFX_OP);
         end
      end
   end

   assign relax_o = pfx_q;
   assign ret_o   = done & pfx_q & (op_q == RET_OP);

endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux
   import irq_chain_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned CODE_LSB = 1,
   localparam int unsigned NSRC    = NUM_CH * SRC_PER_CH,
   localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned CODE_W  = CH_W + 2
) (
   input  logic [VEC_W-1:0]  base_i,
   input  logic              sav_en_i,
   input  logic [NSRC-1:0]   src_i,
   input  logic [NUM_CH-1:0] spec_i,
   output logic [VEC_W-1:0]  vec_o
);

   logic [CODE_W-1:0] code_of [NSRC];
   logic [CODE_W-1:0] code_sel;

   for (genvar k = 0; k < NSRC; k++) begin : g_code
      localparam int unsigned CH   = k / SRC_PER_CH;
      localparam int unsigned KIND = k % SRC_PER_CH;
      localparam logic [CH_W-1:0] CH_TAG = CH_W'(NUM_CH - 1 - CH);
      assign code_of[k] = {CH_TAG, kind_code(KIND, spec_i[CH])};
   end

   always_comb begin
      code_sel = '0;
      for (int k = 0; k < NSRC; k++) begin
         if (src_i[k]) begin
            code_sel = code_sel | code_of[k];
         end
      end
   end

   always_comb begin
      vec_o = base_i;
      if (sav_en_i) begin
         vec_o[CODE_LSB +: CODE_W] = code_sel;
      end
   end

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
   import irq_chain_pkg::*;
#(
   parameter int unsigned     NUM_CH   = 2,
   parameter int unsigned     VEC_W    = 8,
   parameter int unsigned     CODE_LSB = 1,
   parameter int unsigned     OP_W     = 8,
   parameter logic [OP_W-1:0] PFX_OP   = 8'hED,
   parameter logic [OP_W-1:0] RET_OP   = 8'h4D,
   localparam int unsigned    NSRC     = NUM_CH * SRC_PER_CH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   req_i,
   input  logic [NUM_CH-1:0] rx_spec_i,
   input  logic [VEC_W-1:0]  vec_base_i,
   input  logic              sav_en_i,
   input  logic              m1_ni,
   input  logic              iorq_ni,
   input  logic              rd_ni,
   input  logic [OP_W-1:0]   data_i,
   input  logic              iei_i,
   output logic              ieo_o,
   output logic              int_no,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_oe_o
);

   localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned CODE_W = CH_W + 2;
   localparam int unsigned FRZ_W  = NSRC + NUM_CH;

   // Elaboration-time parameter checks
   if (NUM_CH < 2) begin : g_bad_ch
      $error("irq_chain_ctrl: NUM_CH must be at least 2");
   end
   if (CODE_LSB + CODE_W > VEC_W) begin : g_bad_code
      $error("irq_chain_ctrl: source code does not fit in the vector");
   end

   logic fetch;
   logic iack;
   logic iack_q;
   logic ack_start;

   assign fetch     = ~m1_ni & ~rd_ni & iorq_ni;
   assign iack      = ~m1_ni & ~iorq_ni;
   assign ack_start = iack & ~iack_q;

   // Frozen view of the request inputs
   logic [FRZ_W-1:0]  frz_q;
   logic [NSRC-1:0]   pend;
   logic [NUM_CH-1:0] spec;

   irq_status_freeze #(.WIDTH(FRZ_W)) u_freeze (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (~m1_ni),
      .d_i    ({rx_spec_i, req_i}),
      .q_o    (frz_q)
   );

   assign pend = frz_q[NSRC-1:0];
   assign spec = frz_q[FRZ_W-1:NSRC];

   // Return-sequence decode
   logic relax;
   logic ret;

   irq_opcode_mon #(
      .OP_W   (OP_W),
      .PFX_OP (PFX_OP),
      .RET_OP (RET_OP)
   ) u_opmon (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fetch_i (fetch),
      .op_i    (data_i),
      .relax_o (relax),
      .ret_o   (ret)
   );

   // Priority chain
   logic [NSRC-1:0] ius_q;
   logic [NSRC-1:0] grant;
   logic [NSRC-1:0] svc;

   irq_prio_chain #(.NSRC(NSRC)) u_chain (
      .iei_i   (iei_i),
      .pend_i  (pend),
      .ius_i   (ius_q),
      .relax_i (relax),
      .ieo_o   (ieo_o),
      .grant_o (grant),
      .svc_o   (svc)
   );

   // Acknowledge capture and under-service latches
   logic [NSRC-1:0]   ack_src_q;
   logic [NUM_CH-1:0] ack_spec_q;
   logic [NSRC-1:0]   ius_set;
   logic [NSRC-1:0]   ius_clr;

   assign ius_set = ack_start ? grant : '0;
   assign ius_clr = ret ? svc : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         iack_q     <= 1'b0;
         ack_src_q  <= '0;
         ack_spec_q <= '0;
         ius_q      <= '0;
      end else begin
         iack_q <= iack;
         ius_q  <= (ius_q & ~ius_clr) | ius_set;
         if (ack_start) begin
            ack_src_q  <= grant;
            ack_spec_q <= spec;
         end else if (!iack) begin
            ack_src_q  <= '0;
         end
      end
   end

   irq_vec_mux #(
      .NUM_CH   (NUM_CH),
      .VEC_W    (VEC_W),
      .CODE_LSB (CODE_LSB)
   ) u_vec (
      .base_i   (vec_base_i),
      .sav_en_i (sav_en_i),
      .src_i    (ack_src_q),
      .spec_i   (ack_spec_q),
      .vec_o    (vec_o)
   );

   assign vec_oe_o = iack & (|ack_src_q);
   assign int_no   = ~(|grant);

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
   parameter int unsigned NSRC  = 6,
   parameter int unsigned VEC_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             iei_i,
   input logic             ieo_o,
   input logic             int_no,
   input logic             m1_ni,
   input logic             iorq_ni,
   input logic             vec_oe_o,
   input logic [VEC_W-1:0] vec_o,
   input logic [NSRC-1:0]  ius_q
);

   // R2
   ieo_needs_iei_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ieo_o |-> iei_i);

   // R3
   int_needs_iei_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !int_no |-> iei_i);

   // R4
   vec_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_oe_o |-> (!m1_ni && !iorq_ni));

   // R4
   vec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o));

   // R4
   one_new_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ius_q & ~$past(ius_q)) <= 1);

   // R4
   svc_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(ius_q & ~$past(ius_q))) |-> $past(!m1_ni && !iorq_ni));

endmodule

bind irq_chain_ctrl irq_chain_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .iei_i    (iei_i),
   .ieo_o    (ieo_o),
   .int_no   (int_no),
   .m1_ni    (m1_ni),
   .iorq_ni  (iorq_ni),
   .vec_oe_o (vec_oe_o),
   .vec_o    (vec_o),
   .ius_q    (ius_q)
);

// File: tb/irq_chain_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_chain_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] req;
   logic [1:0] spec;
   logic [7:0] base;
   logic       sav;
   logic       m1_n, iorq_n, rd_n;
   logic [7:0] data;
   logic       iei;
   logic       ieo, int_n, vec_oe;
   logic [7:0] vec;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   irq_chain_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rx_spec_i(spec),
      .vec_base_i(base), .sav_en_i(sav), .m1_ni(m1_n), .iorq_ni(iorq_n),
      .rd_ni(rd_n), .data_i(data), .iei_i(iei), .ieo_o(ieo),
      .int_no(int_n), .vec_o(vec), .vec_oe_o(vec_oe)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Expected vector per the source-code table (R5)
   function automatic logic [7:0] exp_vec(input int src, input logic sp, input logic sv,
                                          input logic [7:0] b);
      logic [2:0] c;
      case (src)
         0: c = sp ? 3'b111 : 3'b110;
         1: c = 3'b100;
         2: c = 3'b101;
         3: c = sp ? 3'b011 : 3'b010;
         4: c = 3'b000;
         default: c = 3'b001;
      endcase
      return sv ? {b[7:4], c, b[0]} : b;
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic set_req(input logic [5:0] r);
      @(negedge clk); req = r; step();
   endtask

   task automatic fetch(input logic [7:0] b);
      @(negedge clk); m1_n = 0; rd_n = 0; data = b;
      @(posedge clk);
      @(negedge clk); m1_n = 1; rd_n = 1;
      step();
   endtask

   task automatic reti();
      fetch(8'hED); fetch(8'h4D);
   endtask

   // Acknowledge; checks enable and vector, then releases
   task automatic ack(input string tag, input logic exp_oe, input logic [7:0] exp_v);
      @(negedge clk); m1_n = 0; iorq_n = 0;
      step();
      chk({tag, " oe"}, {7'd0, vec_oe}, {7'd0, exp_oe});
      if (exp_oe) chk({tag, " vec"}, vec, exp_v);
      @(negedge clk); m1_n = 1; iorq_n = 1;
      step();
   endtask

   task automatic t_reset();
      chk("R11 reset int_no", {7'd0, int_n}, 8'd1);
      chk("R11 reset ieo", {7'd0, ieo}, 8'd1);
      chk("R11 reset vec_oe", {7'd0, vec_oe}, 8'd0);
   endtask

   task automatic t_basic();
      set_req(6'b010000);
      chk("R3 pending int_no", {7'd0, int_n}, 8'd0);
      chk("R2 pending ieo", {7'd0, ieo}, 8'd0);
      @(negedge clk); iei = 0; #1;
      chk("R3 iei low int_no", {7'd0, int_n}, 8'd1);
      chk("R2 iei low ieo", {7'd0, ieo}, 8'd0);
      @(negedge clk); iei = 1; #1;
      ack("R5 B tx", 1, exp_vec(4, 0, 1, base));
      set_req(6'b000000);
      chk("R4 served int_no", {7'd0, int_n}, 8'd1);
      chk("R4 served ieo", {7'd0, ieo}, 8'd0);
      fetch(8'hED);
      chk("R8 in-service still blocks", {7'd0, ieo}, 8'd0);
      fetch(8'h4D);
      chk("R9 release ieo", {7'd0, ieo}, 8'd1);
   endtask

   task automatic t_priority_nested();
      set_req(6'b001100);
      ack("R1 A ext over B rx", 1, exp_vec(2, 0, 1, base));
      set_req(6'b001000);
      chk("R1 lower blocked", {7'd0, int_n}, 8'd1);
      set_req(6'b001001);
      chk("R10 nested request", {7'd0, int_n}, 8'd0);
      ack("R10 A rx", 1, exp_vec(0, 0, 1, base));
      set_req(6'b001000);
      chk("R10 both served", {7'd0, int_n}, 8'd1);
      @(negedge clk); iei = 0; #1;
      reti();
      @(negedge clk); iei = 1; #1;
      reti();
      chk("R12 no clear with iei low", {7'd0, int_n}, 8'd1);
      reti();
      chk("R10 lower released last", {7'd0, int_n}, 8'd0);
      @(negedge clk); spec = 2'b10; #1;
      step();
      ack("R5 B rx special", 1, exp_vec(3, 1, 1, base));
      @(negedge clk); req = 6'b0; spec = 2'b00;
      step();
      reti();
      chk("R9 all released", {7'd0, ieo}, 8'd1);
   endtask

   task automatic t_relax();
      set_req(6'b100000);
      fetch(8'hED);
      chk("R8 relax ieo", {7'd0, ieo}, 8'd1);
      fetch(8'h00);
      chk("R8 relax ends", {7'd0, ieo}, 8'd0);
      ack("R5 B ext", 1, exp_vec(5, 0, 1, base));
      set_req(6'b000000);
      fetch(8'hED); fetch(8'h12);
      chk("R9 other byte no clear", {7'd0, ieo}, 8'd0);
      reti();
      chk("R9 ED 4D clears", {7'd0, ieo}, 8'd1);
   endtask

   task automatic t_freeze();
      @(negedge clk); m1_n = 0; rd_n = 0; data = 8'h00;
      @(negedge clk); req = 6'b000010;
      @(posedge clk); @(posedge clk); #1;
      chk("R7 frozen", {7'd0, int_n}, 8'd1);
      @(negedge clk); m1_n = 1; rd_n = 1;
      step();
      chk("R7 taken after release", {7'd0, int_n}, 8'd0);
      @(negedge clk); sav = 0; base = 8'h93; #1;
      ack("R6 plain vector", 1, 8'h93);
      set_req(6'b000000);
      reti();
      ack("R4 no winner", 0, 8'h00);
   endtask

   task automatic t_reset_mid();
      set_req(6'b000010);
      ack("R4 A tx", 1, 8'h93);
      set_req(6'b000000);
      chk("R11 pre-reset ieo", {7'd0, ieo}, 8'd0);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1; #1;
      chk("R11 reset ieo", {7'd0, ieo}, 8'd1);
      set_req(6'b010000);
      chk("R11 service cleared", {7'd0, int_n}, 8'd0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      rst_n = 0; req = '0; spec = '0; base = 8'h40; sav = 1;
      m1_n = 1; iorq_n = 1; rd_n = 1; data = '0; iei = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; #1;
      t_reset();
      t_basic();
      t_priority_nested();
      t_relax();
      t_freeze();
      t_reset_mid();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule